// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Controller

This block holds the machine-mode control and status registers of a small 32-bit core and steps the core through trap entry and trap return. The decode stage presents one CSR access at a time. Each access carries a register number, a 3-bit operation code, a source register value and a 5-bit immediate. The block returns the register's old value for the destination register in the same cycle and commits the new value at the next clock edge.

Exception requests, illegal CSR operations, environment calls and breakpoints are folded into one synchronous trap. A timer interrupt is taken on a retiring instruction that makes no CSR access. Return-from-trap and wait-for-interrupt strobes are handled here as well. For each of these events the block raises a redirect request and supplies the target pc in the same cycle. It also reports the current privilege level and a sleep flag.

Top module: `mtrap_ctrl`

## Requirements
- R1: The operation code selects the new CSR value: 1 writes the source, 2 ORs the source in, 3 clears the source bits, and 5, 6 and 7 do the same with the zero-extended 5-bit immediate as source. The old value appears on `csr_rdata` during the access, and the new value is readable from the next cycle.
- R2: Register 0x301 always reads 0x40401101 and register 0xF11 always reads 0xFF0FF0FF. Writes to either are ignored.
- R3: A register number outside the supported set (0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343, 0x344, 0xC00, 0xF11) reads zero and ignores writes. Writes to the counter (0xC00) and to the pending register (0x344) are also ignored.
- R4: A CSR access with operation code 0 or 4 raises a trap with cause 2, and the addressed register keeps its value.
- R5: On a synchronous trap, the redirect target is the trap vector (0x305) and the saved pc (0x341) takes the pc. The status register (0x300) becomes: bit 7 = old bit 3, bits 12:11 = old privilege, all other bits 0. The privilege becomes machine (3). The trap value (0x343) takes `exc_tval` for causes 5 to 7 and the pc for every other cause.
- R6: ECALL traps with cause 11 in machine mode and with cause 8 in user mode (privilege 0). EBREAK traps with cause 3.
- R7: On MRET, the block redirects to the saved pc. Status bit 3 takes old bit 7, bit 7 is set, bits 12:11 take the old privilege, the other bits are cleared, and the privilege takes old bits 12:11.
- R8: Bit 7 of 0x344 shows `timer_pend` one cycle later. A retiring instruction without CSR access, trap, MRET or WFI takes an interrupt only when that bit, bit 7 of 0x304 and status bit 3 are all set. The interrupt writes cause 0x80000007, trap value 0 and saved pc = pc+4, packs the status register as in R5, keeps the privilege, and redirects to the vector.
- R9: WFI sets status bit 3, redirects to pc+4 and raises `sleep` from the next cycle. `sleep` stays high until a cycle in which `timer_pend` is high.
- R10: The counter (0xC00) increments by one in every cycle in which `instr_retire` is high.
- R11: When several trap sources are active in one cycle, the order is: `exc_valid` first, then an illegal CSR operation, then ECALL, then EBREAK. A trap suppresses that cycle's CSR write, MRET and WFI.
- R12: After reset, the privilege is machine, `sleep` and `redirect_valid` are low, and every writable CSR and the counter read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | A CSR access is presented this cycle |
| csr_addr | input | 12 | CSR number |
| csr_funct3 | input | 3 | CSR operation code |
| csr_rs1 | input | XLEN | Source register value |
| csr_uimm | input | 5 | Immediate source |
| exc_valid | input | 1 | Exception request from another stage |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_tval | input | XLEN | Faulting address for the exception |
| pc | input | XLEN | pc of the current instruction |
| instr_retire | input | 1 | Current instruction retires |
| timer_pend | input | 1 | Timer interrupt pending |
| mret | input | 1 | Return-from-trap strobe |
| ecall | input | 1 | Environment call strobe |
| ebreak | input | 1 | Breakpoint strobe |
| wfi | input | 1 | Wait-for-interrupt strobe |
| csr_rdata | output | XLEN | Old value of the addressed CSR |
| redirect_valid | output | 1 | Next pc must be replaced |
| redirect_pc | output | XLEN | Replacement pc |
| priv | output | 2 | Current privilege level |
| sleep | output | 1 | Core should idle |

## Verification
A wrong packing of the status register stays hidden until the next MRET. At that point it shows as a wrong privilege on `priv` and a wrong status readback, so the bench reads status back right after every trap and every return. A wrong cause or trap-value selection is invisible at the ports until software reads those registers, so each trap scenario reads them in the following cycles. Redirect target errors and privilege errors show on the ports in the cycle of the event or in the cycle after it, and they are checked there.

// File: rtl/mtrap_pkg.sv
// Shared constants for the machine-mode CSR and trap controller.
// Assumes a 32-bit machine with two privilege levels (user, machine).
package mtrap_pkg;
    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_IENABLE = 12'h304;
    localparam logic [11:0] A_VECTOR  = 12'h305;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_IPEND   = 12'h344;
    localparam logic [11:0] A_COUNT   = 12'hC00;
    localparam logic [11:0] A_VENDOR  = 12'hF11;

    localparam logic [31:0] ISA_CONST    = 32'h4040_1101;
    localparam logic [31:0] VENDOR_CONST = 32'hFF0F_F0FF;

    localparam logic [1:0] PRV_USER    = 2'b00;
    localparam logic [1:0] PRV_MACHINE = 2'b11;

    // status bit positions
    localparam int ST_IE    = 3;
    localparam int ST_PIE   = 7;
    localparam int ST_PP_LO = 11;
    localparam int ST_PP_HI = 12;
    localparam int TIMER_BIT = 7;

    // synchronous cause codes
    localparam int CC_ILLEGAL   = 2;
    localparam int CC_BREAK     = 3;
    localparam int CC_CALL_USER = 8;
    localparam int CC_CALL_MACH = 11;
    localparam int CC_TVAL_LO   = 5;
    localparam int CC_TVAL_HI   = 7;
endpackage

// File: rtl/mtrap_csr_op.sv
// Computes the new value of a CSR from the operation code and the source.
// Assumes bit 2 of the code selects the immediate and bits 1:0 select
// write/set/clear; a zero in bits 1:0 marks an illegal operation.
module mtrap_csr_op #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [4:0]      uimm,
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] new_val,
    output logic            bad_op
);
    logic [XLEN-1:0] src;

    // pick register or immediate source
    assign src = funct3[2] ? XLEN'(uimm) : rs1_val;

    // apply write, set or clear
    always_comb begin
        bad_op  = 1'b0;
        new_val = old_val;
        case (funct3[1:0])
            2'b01:   new_val = src;
            2'b10:   new_val = old_val | src;
            2'b11:   new_val = old_val & ~src;
            default: bad_op = 1'b1;
        endcase
    end
endmodule

// File: rtl/mtrap_cause_sel.sv
// Chooses one synchronous trap among the active sources and its trap value.
// Assumes an external exception outranks an illegal CSR operation, which
// outranks ECALL, which outranks EBREAK.
module mtrap_cause_sel
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [XLEN-1:0]    exc_tval,
    input  logic               illegal,
    input  logic               ecall,
    input  logic               ebreak,
    input  logic [1:0]         priv,
    input  logic [XLEN-1:0]    pc,
    output logic               take,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    tval
);
    // priority selection of the cause
    always_comb begin
        take  = 1'b1;
        cause = '0;
        if (exc_valid)        cause = exc_cause;
        else if (illegal)     cause = CAUSE_W'(CC_ILLEGAL);
        else if (ecall)       cause = (priv == PRV_USER) ? CAUSE_W'(CC_CALL_USER)
                                                         : CAUSE_W'(CC_CALL_MACH);
        else if (ebreak)      cause = CAUSE_W'(CC_BREAK);
        else                  take  = 1'b0;
    end

    // trap value: faulting address for access causes, else the pc
    assign tval = (take && exc_valid &&
                   exc_cause >= CAUSE_W'(CC_TVAL_LO) &&
                   exc_cause <= CAUSE_W'(CC_TVAL_HI)) ? exc_tval : pc;
endmodule

// File: rtl/mtrap_ctrl.sv
// Machine-mode CSR file and trap sequencer. Holds status, enable, pending,
// vector, scratch, saved pc, cause, trap value and a retire counter; drives
// redirects for traps, interrupts, MRET and WFI.
// Assumes at most one of mret/wfi per cycle and that trap strobes are only
// valid for the instruction at `pc`.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CYCLE_W = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_valid,
    input  logic [11:0]        csr_addr,
    input  logic [2:0]         csr_funct3,
    input  logic [XLEN-1:0]    csr_rs1,
    input  logic [4:0]         csr_uimm,
    input  logic               exc_valid,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [XLEN-1:0]    exc_tval,
    input  logic [XLEN-1:0]    pc,
    input  logic               instr_retire,
    input  logic               timer_pend,
    input  logic               mret,
    input  logic               ecall,
    input  logic               ebreak,
    input  logic               wfi,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         priv,
    output logic               sleep
);
    localparam logic [XLEN-1:0] IRQ_CAUSE = {1'b1, (XLEN-1)'(TIMER_BIT)};
    localparam logic [XLEN-1:0] PC_STEP   = XLEN'(4);

    logic [XLEN-1:0]    status_q, ienable_q, vector_q, scratch_q;
    logic [XLEN-1:0]    epc_q, cause_q, tval_q;
    logic [CYCLE_W-1:0] count_q;
    logic               tpend_q, sleep_q;
    logic [1:0]         priv_q;

    logic [XLEN-1:0]    old_val, new_val, trap_tval, entry_status, return_status;
    logic [CAUSE_W-1:0] trap_cause;
    logic               bad_op, sync_take, int_take, ret_take, wfi_take, wr;

    // old value of the addressed register
    always_comb begin
        case (csr_addr)
            A_STATUS:  old_val = status_q;
            A_ISA:     old_val = XLEN'(ISA_CONST);
            A_IENABLE: old_val = ienable_q;
            A_VECTOR:  old_val = vector_q;
            A_SCRATCH: old_val = scratch_q;
            A_EPC:     old_val = epc_q;
            A_CAUSE:   old_val = cause_q;
            A_TVAL:    old_val = tval_q;
            A_IPEND:   old_val = XLEN'({tpend_q, {TIMER_BIT{1'b0}}});
            A_COUNT:   old_val = XLEN'(count_q);
            A_VENDOR:  old_val = XLEN'(VENDOR_CONST);
            default:   old_val = '0;
        endcase
    end
    assign csr_rdata = old_val;

    mtrap_csr_op #(.XLEN(XLEN)) u_op (
        .funct3 (csr_funct3),
        .rs1_val(csr_rs1),
        .uimm   (csr_uimm),
        .old_val(old_val),
        .new_val(new_val),
        .bad_op (bad_op)
    );

    mtrap_cause_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_cause (
        .exc_valid(exc_valid),
        .exc_cause(exc_cause),
        .exc_tval (exc_tval),
        .illegal  (csr_valid && bad_op),
        .ecall    (ecall),
        .ebreak   (ebreak),
        .priv     (priv_q),
        .pc       (pc),
        .take     (sync_take),
        .cause    (trap_cause),
        .tval     (trap_tval)
    );

    // event qualification in priority order
    assign wr       = csr_valid && !bad_op && !sync_take;
    assign ret_take = mret && !sync_take;
    assign wfi_take = wfi && !sync_take && !mret;
    assign int_take = instr_retire && !csr_valid && !sync_take && !mret && !wfi &&
                      tpend_q && ienable_q[TIMER_BIT] && status_q[ST_IE];

    // status images for trap entry and return
    always_comb begin
        entry_status                    = '0;
        entry_status[ST_PIE]            = status_q[ST_IE];
        entry_status[ST_PP_HI:ST_PP_LO] = priv_q;
        return_status                    = '0;
        return_status[ST_IE]             = status_q[ST_PIE];
        return_status[ST_PIE]            = 1'b1;
        return_status[ST_PP_HI:ST_PP_LO] = priv_q;
    end

    // redirect request and target
    assign redirect_valid = sync_take || int_take || ret_take || wfi_take;
    assign redirect_pc    = (sync_take || int_take) ? vector_q :
                            ret_take ? epc_q : pc + PC_STEP;

    // status register and privilege
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            priv_q   <= PRV_MACHINE;
        end else if (sync_take || int_take) begin
            status_q <= entry_status;
            if (sync_take) priv_q <= PRV_MACHINE;
        end else if (ret_take) begin
            status_q <= return_status;
            priv_q   <= status_q[ST_PP_HI:ST_PP_LO];
        end else if (wfi_take) begin
            status_q[ST_IE] <= 1'b1;
        end else if (wr && csr_addr == A_STATUS) begin
            status_q <= new_val;
        end
    end

    // trap record: saved pc, cause and trap value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else if (sync_take) begin
            epc_q   <= pc;
            cause_q <= XLEN'(trap_cause);
            tval_q  <= trap_tval;
        end else if (int_take) begin
            epc_q   <= pc + PC_STEP;
            cause_q <= IRQ_CAUSE;
            tval_q  <= '0;
        end else if (wr) begin
            if (csr_addr == A_EPC)   epc_q   <= new_val;
            if (csr_addr == A_CAUSE) cause_q <= new_val;
            if (csr_addr == A_TVAL)  tval_q  <= new_val;
        end
    end

    // plain software registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ienable_q <= '0;
            vector_q  <= '0;
            scratch_q <= '0;
        end else if (wr) begin
            if (csr_addr == A_IENABLE) ienable_q <= new_val;
            if (csr_addr == A_VECTOR)  vector_q  <= new_val;
            if (csr_addr == A_SCRATCH) scratch_q <= new_val;
        end
    end

    // retire counter, pending sample and sleep flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            tpend_q <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            if (instr_retire) count_q <= count_q + CYCLE_W'(1);
            tpend_q <= timer_pend;
            if (wfi_take)        sleep_q <= 1'b1;
            else if (timer_pend) sleep_q <= 1'b0;
        end
    end

    assign priv  = priv_q;
    assign sleep = sleep_q;

    // R5
    sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_take |=> (priv_q == PRV_MACHINE) && (epc_q == $past(pc)));
    // R8
    irq_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> (cause_q == IRQ_CAUSE) && (tval_q == '0));
    // R7
    ret_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> status_q[ST_PIE] && (status_q[ST_IE] == $past(status_q[ST_PIE])));
    // R9
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> $past(wfi));
    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_retire |=> count_q == $past(count_q) + CYCLE_W'(1));
    // R11
    trap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_take && !int_take) |-> redirect_pc == vector_q);
endmodule

// File: tb/mtrap_ctrl_bench.sv
module mtrap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid, exc_valid, instr_retire, timer_pend, mret, ecall, ebreak, wfi;
    logic [11:0] csr_addr;
    logic [2:0]  csr_funct3;
    logic [31:0] csr_rs1, exc_tval, pc;
    logic [4:0]  csr_uimm;
    logic [3:0]  exc_cause;
    logic [31:0] csr_rdata, redirect_pc;
    logic        redirect_valid, sleep;
    logic [1:0]  priv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mtrap_ctrl u_mtrap_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_funct3(csr_funct3), .csr_rs1(csr_rs1), .csr_uimm(csr_uimm),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval),
        .pc(pc), .instr_retire(instr_retire), .timer_pend(timer_pend),
        .mret(mret), .ecall(ecall), .ebreak(ebreak), .wfi(wfi),
        .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv(priv), .sleep(sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        csr_valid = 0; csr_addr = 0; csr_funct3 = 0; csr_rs1 = 0; csr_uimm = 0;
        exc_valid = 0; exc_cause = 0; exc_tval = 0; pc = 0;
        instr_retire = 0; mret = 0; ecall = 0; ebreak = 0; wfi = 0;
    endtask

    task automatic idle();
        @(negedge clk); clr();
    endtask

    task automatic acc(input logic [11:0] a, input logic [2:0] f, input logic [31:0] s,
                       input logic [4:0] u, output logic [31:0] old);
        @(negedge clk); clr();
        csr_valid = 1; csr_addr = a; csr_funct3 = f; csr_rs1 = s; csr_uimm = u;
        #1 old = csr_rdata;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        acc(a, 3'd2, 32'h0, 5'd0, v);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        logic [31:0] o;
        acc(a, 3'd1, v, 5'd0, o);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        idle(); #1;
        chk("R12 priv", 32'(priv), 32'h3);
        chk("R12 sleep", 32'(sleep), 32'h0);
        chk("R12 redirect", 32'(redirect_valid), 32'h0);
        rd(12'h300, v); chk("R12 status", v, 0);
        rd(12'h305, v); chk("R12 vector", v, 0);
        rd(12'hC00, v); chk("R12 counter", v, 0);
    endtask

    task automatic t_ops();
        logic [31:0] v;
        acc(12'h340, 3'd1, 32'hA5A50F0F, 5'd0, v); chk("R1 old value", v, 0);
        rd(12'h340, v); chk("R1 write", v, 32'hA5A50F0F);
        acc(12'h340, 3'd2, 32'h000000F0, 5'd0, v);
        rd(12'h340, v); chk("R1 set", v, 32'hA5A50FFF);
        acc(12'h340, 3'd3, 32'h00000F00, 5'd0, v);
        rd(12'h340, v); chk("R1 clear", v, 32'hA5A500FF);
        acc(12'h340, 3'd5, 32'hFFFFFFFF, 5'h1F, v);
        rd(12'h340, v); chk("R1 write imm", v, 32'h1F);
        acc(12'h340, 3'd6, 32'hFFFFFFFF, 5'h00, v);
        rd(12'h340, v); chk("R1 set imm zero", v, 32'h1F);
        acc(12'h340, 3'd7, 32'hFFFFFFFF, 5'h03, v);
        rd(12'h340, v); chk("R1 clear imm", v, 32'h1C);
    endtask

    task automatic t_const();
        logic [31:0] v;
        wr(12'h301, 0); rd(12'h301, v); chk("R2 isa const", v, 32'h40401101);
        wr(12'hF11, 0); rd(12'hF11, v); chk("R2 vendor const", v, 32'hFF0FF0FF);
        acc(12'h7C0, 3'd1, 32'h1234, 5'd0, v); chk("R3 unlisted old", v, 0);
        rd(12'h7C0, v); chk("R3 unlisted read", v, 0);
        wr(12'hC00, 32'h55); rd(12'hC00, v); chk("R3 counter write ignored", v, 0);
        wr(12'h344, 32'hFFFF); rd(12'h344, v); chk("R3 pending write ignored", v, 0);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        wr(12'h305, 32'h100);
        acc(12'h340, 3'd4, 32'hFFFF, 5'd0, v);
        pc = 32'h50; #1;
        chk("R4 redirect", 32'(redirect_valid), 1);
        chk("R4 target", redirect_pc, 32'h100);
        rd(12'h342, v); chk("R4 cause", v, 2);
        rd(12'h343, v); chk("R4 tval pc", v, 32'h50);
        rd(12'h340, v); chk("R4 no write", v, 32'h1C);
        acc(12'h340, 3'd0, 32'hFFFF, 5'd0, v); pc = 32'h54; #1;
        chk("R4 code zero", 32'(redirect_valid), 1);
        rd(12'h340, v); chk("R4 code zero no write", v, 32'h1C);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        wr(12'h300, 32'h8);
        @(negedge clk); clr();
        exc_valid = 1; exc_cause = 4'd5; exc_tval = 32'hDEAD0000; pc = 32'h60; #1;
        chk("R5 redirect", 32'(redirect_valid), 1);
        chk("R5 target", redirect_pc, 32'h100);
        rd(12'h342, v); chk("R5 cause", v, 5);
        rd(12'h343, v); chk("R5 tval addr", v, 32'hDEAD0000);
        rd(12'h341, v); chk("R5 epc", v, 32'h60);
        rd(12'h300, v); chk("R5 status pack", v, 32'h1880);
        @(negedge clk); clr();
        exc_valid = 1; exc_cause = 4'd1; exc_tval = 32'h1234; pc = 32'h64;
        rd(12'h343, v); chk("R5 tval pc", v, 32'h64);
        rd(12'h300, v); chk("R5 status pack2", v, 32'h1800);
    endtask

    task automatic t_calls();
        logic [31:0] v;
        wr(12'h300, 0); wr(12'h341, 32'h200);
        @(negedge clk); clr(); mret = 1; pc = 32'h70; #1;
        chk("R7 target", redirect_pc, 32'h200);
        idle(); #1; chk("R7 priv user", 32'(priv), 0);
        @(negedge clk); clr(); ecall = 1; pc = 32'h204; #1;
        chk("R6 target", redirect_pc, 32'h100);
        rd(12'h342, v); chk("R6 user call", v, 8);
        chk("R6 priv machine", 32'(priv), 3);
        rd(12'h300, v); chk("R6 status", v, 32'h0);
        @(negedge clk); clr(); ecall = 1; pc = 32'h208;
        rd(12'h342, v); chk("R6 machine call", v, 11);
        @(negedge clk); clr(); ebreak = 1; pc = 32'h20C;
        rd(12'h342, v); chk("R6 break", v, 3);
        rd(12'h343, v); chk("R6 break tval", v, 32'h20C);
    endtask

    task automatic t_mret();
        logic [31:0] v;
        wr(12'h341, 32'h2000); wr(12'h300, 32'h1880);
        @(negedge clk); clr(); mret = 1; pc = 32'h80; #1;
        chk("R7 redirect", 32'(redirect_valid), 1);
        chk("R7 target epc", redirect_pc, 32'h2000);
        rd(12'h300, v); chk("R7 status", v, 32'h1888);
        chk("R7 priv", 32'(priv), 3);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(12'h304, 32'h80); wr(12'h300, 32'h0);
        timer_pend = 1;
        rd(12'h344, v); rd(12'h344, v); chk("R8 pending bit", v, 32'h80);
        @(negedge clk); clr(); instr_retire = 1; pc = 32'h3000; #1;
        chk("R8 masked by status", 32'(redirect_valid), 0);
        wr(12'h300, 32'h8);
        @(negedge clk); clr(); instr_retire = 1; pc = 32'h3000; #1;
        chk("R8 taken", 32'(redirect_valid), 1);
        chk("R8 target", redirect_pc, 32'h100);
        rd(12'h342, v); chk("R8 cause", v, 32'h80000007);
        rd(12'h343, v); chk("R8 tval", v, 0);
        rd(12'h341, v); chk("R8 epc next", v, 32'h3004);
        rd(12'h300, v); chk("R8 status", v, 32'h1880);
        timer_pend = 0;
        wr(12'h304, 0);
    endtask

    task automatic t_wfi();
        logic [31:0] v;
        wr(12'h300, 0);
        @(negedge clk); clr(); wfi = 1; pc = 32'h400; #1;
        chk("R9 redirect", 32'(redirect_valid), 1);
        chk("R9 target", redirect_pc, 32'h404);
        idle(); #1; chk("R9 sleep set", 32'(sleep), 1);
        rd(12'h300, v); chk("R9 status ie", v, 32'h8);
        idle(); #1; chk("R9 sleep held", 32'(sleep), 1);
        @(negedge clk); timer_pend = 1;
        idle(); #1; chk("R9 sleep cleared", 32'(sleep), 0);
        timer_pend = 0;
    endtask

    task automatic t_count();
        logic [31:0] c0, v;
        rd(12'hC00, c0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); clr(); instr_retire = 1; pc = 32'h500;
        end
        rd(12'hC00, v); chk("R10 counter", v, c0 + 3);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        acc(12'h340, 3'd4, 32'h0, 5'd0, v);
        exc_valid = 1; exc_cause = 4'd7; exc_tval = 32'hABC; ecall = 1; pc = 32'h90;
        rd(12'h342, v); chk("R11 exception first", v, 7);
        rd(12'h343, v); chk("R11 tval", v, 32'hABC);
        @(negedge clk); clr(); ecall = 1; ebreak = 1; pc = 32'h94;
        rd(12'h342, v); chk("R11 call over break", v, 11);
        wr(12'h341, 32'h7000);
        @(negedge clk); clr(); ebreak = 1; mret = 1; pc = 32'h98; #1;
        chk("R11 trap over mret", redirect_pc, 32'h100);
        rd(12'h341, v); chk("R11 mret suppressed", v, 32'h98);
    endtask

    initial begin
        clr(); timer_pend = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_ops();
        t_const();
        t_illegal();
        t_sync();
        t_calls();
        t_mret();
        t_irq();
        t_wfi();
        t_count();
        t_prio();
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule